// File: doc/BRIEF.md
# Output Clock Stop and Restart Sequencer

This block sits between a synthesized clock and the pad drivers of a clock generator. It decides when the differential output pair and the single-ended reference output may toggle. Two separate stop paths control it. An asynchronous, active-high power-down input halts everything and asks the PLL and oscillator to power down. A software output-enable bit silences only the differential pair and leaves the PLL running.

The power-down request passes through a two-stage synchronizer before it acts. When the request is released, the outputs stay quiet for a programmable number of reference cycles while the oscillator settles. Each gate enable is registered on the falling edge of the clock, so a gated output only starts or stops while the clock is low. Every pulse that leaves the block therefore has a full-width high phase. A `running` status output shows when the sequencer is in its active state.

Top module: `clkseq_top`

## Requirements
- R1: The power-down input passes through a two-flop synchronizer. After `pd_async` rises between edges, `pll_pd` goes high on the third rising clock edge that follows.
- R2: While halted (`pll_pd` = 1), `diff_oe` and `ref_oe` are 0 and `diff_p`, `diff_n` and `ref_out` are held at 0.
- R3: Every high phase of `diff_p` and `ref_out` starts on a rising clock edge and lasts a full half period. Every high phase of `diff_n` starts while the clock is low. Enables change only on falling clock edges.
- R4: After `pd_async` falls between edges, `running` rises on rising edge number `settle_cycles` + 3 counted from the release, with a `settle_cycles` value of 0 treated as 1. Until then `ref_oe` and `diff_oe` stay 0. `ref_oe` rises on the next falling edge.
- R5: If power-down returns during the settling wait, `pll_pd` rises again on the third rising edge. The wait restarts from zero after the next release.
- R6: When `out_en` is 0 during the active state, `diff_oe` is 0 and `diff_p` is held low from the next falling edge. `ref_oe` and `running` stay 1 and `pll_pd` stays 0.
- R7: When `out_en` returns to 1, `diff_oe` rises on the next falling edge and the differential output resumes with full-width pulses.
- R8: During reset the block is in the settling state: every enable is 0, and `pll_pd` and `running` are 0. After reset release, `running` rises on rising edge number `settle_cycles` (0 treated as 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized clock to be gated; also times the settle counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_async | input | 1 | Asynchronous active-high power-down request |
| out_en | input | 1 | Software enable for the differential output (1 = on) |
| settle_cycles | input | CW | Length of the settling wait in clock cycles |
| diff_p | output | 1 | Gated true side of the differential output |
| diff_n | output | 1 | Gated complement side of the differential output |
| diff_oe | output | 1 | Drive enable for the differential pads (0 = high impedance) |
| ref_out | output | 1 | Gated reference output |
| ref_oe | output | 1 | Drive enable for the reference pad |
| pll_pd | output | 1 | Request to power down the PLL and oscillator |
| running | output | 1 | High while the sequencer is in the active state |

## Verification
A corrupted state register or a settle counter that does not restart would show at the ports as a change in the count of rising edges between release and `running`. The bench measures that count exactly for every release, so the error appears on the first restart after it occurs. An enable flop that sampled on the wrong edge would produce a short high phase on `diff_p` or `ref_out`. A pulse-width monitor catches that within half a clock period. A wrong decode of the halted state would show up in the next cycle as a live enable while `pll_pd` is high, or as a raised `pll_pd` while only `out_en` is low.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [1:0] {
    SQ_SETTLE = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_HALT   = 2'd2
  } seq_state_e;

  // Index of the final settle cycle; a request of zero cycles behaves as one.
  function automatic logic [31:0] last_index(input logic [31:0] cycles);
    return (cycles == 32'd0) ? 32'd0 : cycles - 32'd1;
  endfunction

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic [CW-1:0] settle_cycles,
  output seq_state_e    state,
  output logic [CW-1:0] settle_cnt,
  output logic [CW-1:0] settle_last
);
  assign settle_last = CW'(last_index(32'(settle_cycles)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_SETTLE;
      settle_cnt <= '0;
    end else begin
      unique case (state)
        SQ_RUN: begin
          if (pd_req) state <= SQ_HALT;
        end
        SQ_HALT: begin
          if (!pd_req) begin
            state      <= SQ_SETTLE;
            settle_cnt <= '0;
          end
        end
        SQ_SETTLE: begin
          if (pd_req)                         state <= SQ_HALT;
          else if (settle_cnt == settle_last) state <= SQ_RUN;
          else                                settle_cnt <= settle_cnt + 1'b1;
        end
        default: state <= SQ_HALT;
      endcase
    end
  end
endmodule

// File: rtl/clkseq_gate.sv
module clkseq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic clk_gated,
  output logic oe
);
  logic en_q;

  // Sampled while the clock falls, so the enable only moves during the low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_req;
  end

  assign clk_gated = clk & en_q;
  assign oe        = en_q;
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_async,
  input  logic          out_en,
  input  logic [CW-1:0] settle_cycles,
  output logic          diff_p,
  output logic          diff_n,
  output logic          diff_oe,
  output logic          ref_out,
  output logic          ref_oe,
  output logic          pll_pd,
  output logic          running
);
  logic          pd_sync;
  seq_state_e    st;
  logic [CW-1:0] settle_cnt;
  logic [CW-1:0] settle_last;
  logic          settling;
  logic          halted;
  logic          diff_req;

  clkseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pd_async),
    .q     (pd_sync)
  );

  clkseq_fsm #(.CW(CW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_req        (pd_sync),
    .settle_cycles (settle_cycles),
    .state         (st),
    .settle_cnt    (settle_cnt),
    .settle_last   (settle_last)
  );

  assign settling = (st == SQ_SETTLE);
  assign halted   = (st == SQ_HALT);
  assign running  = (st == SQ_RUN);
  assign pll_pd   = halted;
  assign diff_req = running & out_en;

  clkseq_gate u_gate_diff (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (diff_req),
    .clk_gated (diff_p),
    .oe        (diff_oe)
  );

  clkseq_gate u_gate_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (running),
    .clk_gated (ref_out),
    .oe        (ref_oe)
  );

  assign diff_n = ~clk & diff_oe;
endmodule

// File: rtl/clkseq_checker.sv
module clkseq_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_async,
  input logic          pll_pd,
  input logic          diff_oe,
  input logic          ref_oe,
  input logic          settling,
  input logic [CW-1:0] settle_cnt,
  input logic [CW-1:0] settle_last
);
  // R1: a rise of the power-down request follows the input two samples back
  a_r1_sync_path: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_pd) |-> $past(pd_async, 2));

  // R2: a halt held across a falling edge leaves every enable off
  a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_pd && $past(pll_pd)) |-> (!ref_oe && !diff_oe));

  // R4: nothing drives while the settle wait is in progress
  a_r4_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (!ref_oe && !diff_oe));

  // R4: the wait counter never passes its final index
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (settle_cnt <= settle_last));

  // R5: every wait that follows a halt starts from zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && $past(pll_pd)) |-> (settle_cnt == '0));

  // R6: the reference alone running implies the PLL is kept on
  a_r6_pll_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_oe && !diff_oe) |-> !pll_pd);
endmodule

bind clkseq_top clkseq_checker #(.CW(CW)) u_clkseq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pd_async    (pd_async),
  .pll_pd      (pll_pd),
  .diff_oe     (diff_oe),
  .ref_oe      (ref_oe),
  .settling    (settling),
  .settle_cnt  (settle_cnt),
  .settle_last (settle_last)
);

// File: tb/clkseq_top_bench.sv
`timescale 1ns/1ps
module clkseq_top_bench;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, pd_async, out_en;
  logic [CW-1:0] settle_cycles;
  logic diff_p, diff_n, diff_oe, ref_out, ref_oe, pll_pd, running;

  clkseq_top #(.CW(CW)) u_clkseq_top (
    .clk(clk), .rst_n(rst_n), .pd_async(pd_async), .out_en(out_en),
    .settle_cycles(settle_cycles), .diff_p(diff_p), .diff_n(diff_n),
    .diff_oe(diff_oe), .ref_out(ref_out), .ref_oe(ref_oe),
    .pll_pd(pll_pd), .running(running)
  );

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit done = 0;

  // R3 monitor: pulse widths and phase alignment
  realtime t_d = 0.0, t_r = 0.0;
  bit v_d = 0, v_r = 0;
  always @(posedge diff_p) begin if (!clk) glitches++; t_d = $realtime; v_d = 1; end
  always @(negedge diff_p) if (v_d && ($realtime - t_d) != 5.0) glitches++;
  always @(posedge ref_out) begin if (!clk) glitches++; t_r = $realtime; v_r = 1; end
  always @(negedge ref_out) if (v_r && ($realtime - t_r) != 5.0) glitches++;
  always @(posedge diff_n) if (clk) glitches++;

  function automatic int settle_len(int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int release_latency(int n);
    return 3 + settle_len(n);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic edges_until_run(output int k);
    k = 0;
    while (!running && k < 5000) begin @(posedge clk); #1; k++; end
  endtask

  task automatic edges_until_halt(output int k);
    k = 0;
    while (!pll_pd && k < 5000) begin @(posedge clk); #1; k++; end
  endtask

  task automatic pd_cycle(int n, int hold);
    int k;
    settle_cycles = CW'(n);
    pd_async = 1'b1;
    edges_until_halt(k);
    chk(k == 3, "R1 halt edge", k, 3);
    repeat (hold) step();
    chk(!diff_oe && !ref_oe && !diff_p && !ref_out, "R2 halted outputs",
        {diff_oe, ref_oe, diff_p, ref_out}, 0);
    pd_async = 1'b0;
    edges_until_run(k);
    chk(k == release_latency(n), "R4 release latency", k, release_latency(n));
    chk(!ref_oe, "R4 ref_oe before fall", ref_oe, 0);
    step();
    chk(ref_oe && !pll_pd, "R4 ref_oe after fall", {ref_oe, pll_pd}, 2);
  endtask

  initial begin
    int k;
    void'($urandom(32'd2718));
    rst_n = 1'b0; pd_async = 1'b0; out_en = 1'b1; settle_cycles = CW'(4);
    repeat (3) step();
    chk(!diff_oe && !ref_oe && !pll_pd && !running, "R8 reset state",
        {diff_oe, ref_oe, pll_pd, running}, 0);
    rst_n = 1'b1;
    edges_until_run(k);
    chk(k == settle_len(4), "R8 boot latency", k, settle_len(4));
    step();
    chk(diff_oe && ref_oe, "R8 enables after boot", {diff_oe, ref_oe}, 3);

    pd_cycle(5, 3);
    pd_cycle(0, 1);
    pd_cycle(1, 4);

    // R5: reassert in the middle of the wait
    settle_cycles = CW'(6);
    pd_async = 1'b1;
    edges_until_halt(k);
    step(); step();
    pd_async = 1'b0;
    repeat (6) step();
    chk(!running && !ref_oe, "R5 still waiting", {running, ref_oe}, 0);
    pd_async = 1'b1;
    edges_until_halt(k);
    chk(k == 3, "R5 halt from wait", k, 3);
    step();
    pd_async = 1'b0;
    edges_until_run(k);
    chk(k == release_latency(6), "R5 restart latency", k, release_latency(6));
    step();

    // R6 / R7: software enable path
    out_en = 1'b0;
    step();
    chk(!diff_oe && !diff_p, "R6 diff off", {diff_oe, diff_p}, 0);
    chk(ref_oe && running && !pll_pd, "R6 ref and PLL kept",
        {ref_oe, running, pll_pd}, 6);
    repeat (4) step();
    chk(!diff_oe && ref_out, "R6 ref toggling", {diff_oe, ref_out}, 1);
    out_en = 1'b1;
    step();
    chk(diff_oe && diff_p, "R7 diff back", {diff_oe, diff_p}, 3);

    // Mixed random sequences
    for (int i = 0; i < 14; i++) begin
      int n, hold;
      bit oe;
      n    = $urandom_range(0, 12);
      hold = $urandom_range(1, 6);
      oe   = 1'($urandom_range(0, 1));
      #($urandom_range(0, 2));
      out_en = oe;
      pd_cycle(n, hold);
      step();
      chk(diff_oe == oe, "R6 random enable", diff_oe, oe);
      out_en = 1'b1;
      step();
    end

    step();
    chk(glitches == 0, "R3 pulse integrity", glitches, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule